// File: doc/BRIEF.md
# Power-of-Two Prescaled Up-Timer

This block is a general-purpose timer that counts upward. A prescaler divides the clock by a power of two, and software chooses that ratio by writing an exponent, not a divisor. On each prescaled tick the main counter steps by one. When it passes a programmable reload value it returns to zero. That overflow is an update event. At an update event the block emits a one-cycle pulse, sets a sticky interrupt flag and transfers the buffered exponent into the active prescaler.

Software sees a small write-only register interface. Through it, software can start and stop counting, force an update, block update events entirely, and stop forced updates from raising the interrupt flag. It clears the flag by writing a one. A new exponent written while the timer is running never changes the ratio in the middle of a period. It waits for the next update event.

Top module: `pow2_uptimer`

## Requirements
- R1: After reset the counter value, the update pulse and the interrupt flag are 0, the active and buffered exponents are 0, the reload value is 0 and the timer is stopped.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. Address 0 is control, 1 is the exponent (bits 3:0) and 2 is the reload value. Address 3 is ignored. Control bits: 0 run, 1 hold-updates, 2 quiet-forced, 3 force-update, 4 flag-clear. Bits 0 and 1 are stored. Bits 2, 3 and 4 act only in the write cycle itself.
- R3: While run is 1, the counter advances once every 2^E clock cycles, where E is the active exponent (0 to 15, so the ratio spans 1 to 32768). While run is 0, the counter and the prescaler hold their values.
- R4: The counter steps 0, 1, ..., reload. On the tick after it reaches reload it wraps to 0, which is an overflow. With reload 0 the counter stays at 0 and every tick is an overflow.
- R5: An overflow while hold-updates is 0 is an update event. `upd_pulse` is high for exactly the cycle after the clock edge of the overflow, and `irq_flag` is set at that same edge.
- R6: A written exponent is buffered. It becomes the active exponent only at the next update event.
- R7: A control write with force-update 1 and hold-updates 0 is a software update. It gives one `upd_pulse` cycle and resets both the counter and the prescaler to 0 at its write edge. The force bit is never stored, so one write gives exactly one pulse.
- R8: While hold-updates is 1, overflows still wrap the counter. They give no pulse, no flag and no exponent transfer, and a force-update write has no effect. Updates resume once the bit is written back to 0.
- R9: A software update whose write has quiet-forced 1 does not set `irq_flag`. A software update whose write has quiet-forced 0 sets it. Overflow updates set it regardless of quiet-forced.
- R10: `irq_flag` stays set until a control write with flag-clear 1. If a set and a clear land in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W (16) | Write data |
| cnt_value | output | CNT_W (16) | Current main counter value |
| upd_pulse | output | 1 | One-cycle update event pulse |
| irq_flag | output | 1 | Sticky update interrupt flag |

## Verification
The bench changes the exponent while the timer runs and checks the counter on either side of the next overflow. A design that applied the exponent at the write would show the wrong count there. It forces an update halfway through a prescaler period and samples the counter at the old and the new tick positions. A design that restarted only the main counter would tick early. While updates are held it writes a new exponent, lets an overflow pass and issues a force write. A leaking design would then emit a pulse, set the flag, reset the count or switch ratio. Finally it runs with reload 0 at the largest exponent, and it makes a forced update collide with a flag clear. An off-by-one mask would misplace the single overflow, and a clear-priority flag would read 0.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;
   localparam logic [1:0] ADDR_CTRL   = 2'd0;
   localparam logic [1:0] ADDR_EXP    = 2'd1;
   localparam logic [1:0] ADDR_RELOAD = 2'd2;

   localparam int BIT_RUN   = 0;
   localparam int BIT_HOLD  = 1;
   localparam int BIT_QUIET = 2;
   localparam int BIT_FORCE = 3;
   localparam int BIT_CLR   = 4;
   localparam int CTRL_BITS = 5;

   typedef struct packed {
      logic run;
      logic hold;
   } ctrl_t;
endpackage

// File: rtl/uptimer_regs.sv
module uptimer_regs
   import uptimer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int EXP_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output ctrl_t            ctrl_q,
   output logic [EXP_W-1:0] exp_buf_q,
   output logic [CNT_W-1:0] reload_q,
   output logic             sw_upd,
   output logic             sw_quiet,
   output logic             flag_clr
);
   logic ctrl_wr;

   assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
   // force acts on the hold bit carried by the same write
   assign sw_upd   = ctrl_wr && wr_data[BIT_FORCE] && !wr_data[BIT_HOLD];
   assign sw_quiet = wr_data[BIT_QUIET];
   assign flag_clr = ctrl_wr && wr_data[BIT_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         exp_buf_q <= '0;
         reload_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: begin
               ctrl_q.run  <= wr_data[BIT_RUN];
               ctrl_q.hold <= wr_data[BIT_HOLD];
            end
            ADDR_EXP:    exp_buf_q <= wr_data[EXP_W-1:0];
            ADDR_RELOAD: reload_q  <= wr_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/uptimer_prescaler.sv
module uptimer_prescaler #(
   parameter int EXP_W = 4,
   parameter int PSC_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             load_exp,
   input  logic [EXP_W-1:0] exp_buf,
   output logic             tick
);
   logic [EXP_W-1:0] act_exp_q;
   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;

   // terminal count 2^E-1 as a thermometer mask, one bit per stage
   for (genvar gi = 0; gi < PSC_W; gi++) begin : g_mask
      assign mask[gi] = (int'(act_exp_q) > gi);
   end

   assign tick = run && (psc_q == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q <= '0;
      end else if (restart || tick) begin
         psc_q <= '0;
      end else if (run) begin
         psc_q <= psc_q + PSC_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_exp_q <= '0;
      end else if (load_exp) begin
         act_exp_q <= exp_buf;
      end
   end
endmodule

// File: rtl/uptimer_counter.sv
module uptimer_counter #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   assign wrap = tick && (cnt_q == reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pow2_uptimer.sv
module pow2_uptimer
   import uptimer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int EXP_W = 4,
   parameter int PSC_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_value,
   output logic             upd_pulse,
   output logic             irq_flag
);
   localparam int MAX_SHIFT = (1 << EXP_W) - 1;

   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("EXP_W must lie in 1..5");
   end
   if (PSC_W < MAX_SHIFT) begin : g_bad_psc
      $error("PSC_W too narrow for the largest exponent");
   end
   if (CNT_W < CTRL_BITS) begin : g_bad_cnt
      $error("CNT_W must hold every control bit");
   end

   ctrl_t            ctrl_q;
   logic [EXP_W-1:0] exp_buf_q;
   logic [CNT_W-1:0] reload_q;
   logic             sw_upd, sw_quiet, flag_clr;
   logic             tick, cnt_wrap;
   logic             ovf_upd, upd_evt, flag_set;
   logic             pulse_q, flag_q;

   uptimer_regs #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl_q(ctrl_q), .exp_buf_q(exp_buf_q),
      .reload_q(reload_q), .sw_upd(sw_upd), .sw_quiet(sw_quiet),
      .flag_clr(flag_clr)
   );

   uptimer_prescaler #(.EXP_W(EXP_W), .PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .restart(sw_upd),
      .load_exp(upd_evt), .exp_buf(exp_buf_q), .tick(tick)
   );

   uptimer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_upd),
      .reload(reload_q), .cnt_q(cnt_value), .wrap(cnt_wrap)
   );

   assign ovf_upd  = cnt_wrap && !ctrl_q.hold;
   assign upd_evt  = ovf_upd || sw_upd;
   assign flag_set = ovf_upd || (sw_upd && !sw_quiet);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         pulse_q <= upd_evt;
         if (flag_set)      flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   assign upd_pulse = pulse_q;
   assign irq_flag  = flag_q;
endmodule

// File: rtl/pow2_uptimer_chk.sv
module pow2_uptimer_chk #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] cnt_value,
   input logic             upd_pulse,
   input logic             irq_flag,
   input logic             hold_q,
   input logic             cnt_wrap
);
   logic ctrl_wr;
   assign ctrl_wr = wr_en && (wr_addr == 2'd0);

   AST_FLAG_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> upd_pulse);                                         // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !(ctrl_wr && wr_data[4])) |=> irq_flag);                   // R10
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_value) |-> (cnt_value == '0 ||
         cnt_value == CNT_W'($past(cnt_value) + CNT_W'(1))));                 // R4
   AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !ctrl_wr) |=> !upd_pulse);                                   // R8
   AST_FORCE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[3] && !wr_data[1]) |=> (upd_pulse && cnt_value == '0)); // R7
   AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[3] && !wr_data[1] && wr_data[2] && !irq_flag &&
       !(cnt_wrap && !hold_q)) |=> !irq_flag);                                // R9
endmodule

bind pow2_uptimer pow2_uptimer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .cnt_value(cnt_value), .upd_pulse(upd_pulse),
   .irq_flag(irq_flag), .hold_q(ctrl_q.hold), .cnt_wrap(cnt_wrap)
);

// File: tb/tb_pow2_uptimer.sv
module tb_pow2_uptimer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam logic [15:0] RUN = 16'h01, HOLD = 16'h02, QUIET = 16'h04,
                           FORCE = 16'h08, CLR = 16'h10;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             wr_en;
   logic [1:0]       wr_addr;
   logic [CNT_W-1:0] wr_data;
   logic [CNT_W-1:0] cnt_value;
   logic             upd_pulse, irq_flag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];
   int p0, s1;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pow2_uptimer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_value(cnt_value), .upd_pulse(upd_pulse),
      .irq_flag(irq_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, expv);
      end
   endtask

   // driver side of the scoreboard: one expected pulse cycle per entry
   task automatic push(input int c);
      exp_q.push_back(c);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic at(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic wr_at(input int t, input logic [1:0] a, input logic [15:0] d);
      at(t - 1);
      wr(a, d);
   endtask

   // monitor side: every pulse must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (exp_q.size() != 0 && exp_q[0] < cyc) begin
            chk(1'b0, "R5/R7 missed pulse", 0, exp_q[0]);
            void'(exp_q.pop_front());
         end
         if (upd_pulse) begin
            if (exp_q.size() != 0 && exp_q[0] == cyc) begin
               chk(1'b1, "R5/R7", cyc, cyc);
               void'(exp_q.pop_front());
            end else begin
               chk(1'b0, "R5/R7/R8 unexpected pulse", cyc,
                   exp_q.size() != 0 ? exp_q[0] : -1);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cnt_value == 0, "R1 cnt", int'(cnt_value), 0);
      chk(upd_pulse == 0, "R1 pulse", int'(upd_pulse), 0);
      chk(irq_flag == 0, "R1 flag", int'(irq_flag), 0);

      wr(2'd2, 16'd3);                         // R2 reload = 3
      p0 = cyc + 1;
      push(p0+4); push(p0+8); push(p0+24); push(p0+30);
      push(p0+46); push(p0+78); push(p0+82); push(p0+84);
      wr(2'd0, RUN);

      at(p0+2);  chk(cnt_value == 2, "R3 divide by 1", int'(cnt_value), 2);
      at(p0+4);  chk(cnt_value == 0, "R4 wrap", int'(cnt_value), 0);
                 chk(irq_flag == 1, "R5 flag on overflow", int'(irq_flag), 1);
      wr_at(p0+6, 2'd1, 16'd2);                // R6 exponent written on the fly
      at(p0+10); chk(cnt_value == 0, "R6 not yet applied", int'(cnt_value), 0);
      at(p0+12); chk(cnt_value == 1, "R6 applied at update", int'(cnt_value), 1);
      at(p0+24); chk(irq_flag == 1, "R10 sticky", int'(irq_flag), 1);
      wr_at(p0+29, 2'd0, RUN | CLR);
      chk(irq_flag == 0, "R10 clear", int'(irq_flag), 0);
      wr_at(p0+30, 2'd0, RUN | QUIET | FORCE);
      chk(irq_flag == 0, "R9 quiet force", int'(irq_flag), 0);
      chk(cnt_value == 0, "R7 restart", int'(cnt_value), 0);
      at(p0+33); chk(cnt_value == 0, "R7 prescaler restart", int'(cnt_value), 0);
      at(p0+34); chk(cnt_value == 1, "R7 first tick", int'(cnt_value), 1);
      at(p0+46); chk(irq_flag == 1, "R9 overflow ignores quiet", int'(irq_flag), 1);
      wr_at(p0+47, 2'd0, RUN | HOLD | CLR);
      wr_at(p0+48, 2'd1, 16'd0);
      at(p0+63); chk(irq_flag == 0, "R8 no flag while held", int'(irq_flag), 0);
      wr_at(p0+64, 2'd0, RUN | HOLD | FORCE);
      at(p0+66); chk(cnt_value == 1, "R8 force and exponent ignored", int'(cnt_value), 1);
      wr_at(p0+67, 2'd0, RUN);
      at(p0+78); chk(irq_flag == 1, "R8 updates resume", int'(irq_flag), 1);
      at(p0+81); chk(cnt_value == 3, "R6 new exponent after resume", int'(cnt_value), 3);
      wr_at(p0+84, 2'd0, QUIET | FORCE | CLR);
      chk(irq_flag == 0, "R10 clear with quiet force", int'(irq_flag), 0);
      at(p0+90); chk(cnt_value == 0, "R3 stopped holds", int'(cnt_value), 0);

      push(cyc + 1);
      wr(2'd0, FORCE);
      chk(irq_flag == 1, "R9 loud force sets flag", int'(irq_flag), 1);
      push(cyc + 1);
      wr(2'd0, FORCE | CLR);
      chk(irq_flag == 1, "R10 set beats clear", int'(irq_flag), 1);

      wr(2'd2, 16'd0);
      wr(2'd1, 16'd15);
      push(cyc + 1);
      wr(2'd0, QUIET | FORCE | CLR);
      chk(irq_flag == 0, "R10 cleared", int'(irq_flag), 0);
      s1 = cyc + 1;
      push(s1 + 32768);
      wr(2'd0, RUN);
      at(s1+32767);
      chk(irq_flag == 0, "R3 max ratio not early", int'(irq_flag), 0);
      chk(cnt_value == 0, "R4 reload 0 holds", int'(cnt_value), 0);
      at(s1+32768);
      chk(irq_flag == 1, "R4 reload 0 overflow", int'(irq_flag), 1);
      chk(cnt_value == 0, "R4 reload 0 stays", int'(cnt_value), 0);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5 pending pulses", exp_q.size(), 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule